// File: doc/BRIEF.md
# Dual-Rate Token Bucket Meter

This block meters packets against a table of paired token buckets. The table holds `DUALS` dual meters, 256 by default. Dual meter `i` uses a committed bucket at single-bucket index `i` and a peak bucket at index `i + DUALS`. Each bucket keeps a credit count, a last-update timestamp, a maximum burst and a refill rate. The rate is a 12-bit mantissa scaled down by a 6-bit exponent. One byte costs 16 credits, and both the credit count and the burst are held in credits.

Per packet, the caller supplies a dual-meter index, two lengths and an input colour. The two lengths are the length before and after the packet was modified. The block refills both buckets lazily for the ticks that elapsed since each bucket was last touched. Committed overflow spills into the peak bucket. The block then picks a colour, debits the buckets that the chosen behaviour charges, and stores the new credits and the current tick count. Four behaviours are selectable per meter: plain two-rate and differentiated two-rate, each in a colour-blind and a colour-aware form.

A minimal write port loads one bucket per cycle; this stands in for the host path. An external tick strobe advances the 24-bit timer that drives the refill.

Top module: `dual_rate_meter`

## Requirements
- R1: After reset `res_valid` is 0, the timer is 0 and every bucket is cleared with its enable off, so a packet to any meter is answered green (colour code 0).
- R2: When the committed entry's enable bit is 0, a packet is answered green and neither bucket of the pair is modified: no credit and no timestamp changes.
- R3: A write on the configuration port stores burst, exponent, mantissa, mode, length type and enable for bucket `cfg_idx` (0..2·DUALS-1). It sets that bucket's credits equal to the burst and its timestamp to 0. If a packet touches the same bucket in the same cycle, the configuration write wins.
- R4: A packet of L bytes conforms to a bucket only when that bucket's credits after refill are at least 16·L. A conforming debit subtracts exactly 16·L.
- R5: Before the decision, each bucket gains (mantissa × N) >> exponent credits. N is (timer − stored timestamp) mod 2^24. The credit count saturates at the bucket's burst, and both timestamps are rewritten with the current timer.
- R6: Credits refilled into the committed bucket beyond its burst are added to the peak bucket's refill, which then saturates at the peak burst.
- R7: Mode 0 (two-rate, colour-blind): red with no debit if peak credits < 16·L. Otherwise yellow with a peak-only debit if committed credits < 16·L. Otherwise green with both buckets debited.
- R8: Mode 1 (two-rate, colour-aware): an input of red (code 2 or 3) gives red with no debit. An input of yellow (code 1) gives red if the peak does not conform, else yellow with a peak debit. An input of green (code 0) behaves as mode 0.
- R9: Mode 2 (differentiated, colour-blind): green with a committed-only debit if the committed bucket conforms. Otherwise yellow with a peak-only debit if the peak conforms. Otherwise red.
- R10: Mode 3 (differentiated, colour-aware): an input of red gives red with no debit. An input of yellow tries only the peak bucket and gives yellow with a peak debit, or red. An input of green behaves as mode 2.
- R11: The committed entry's length-type bit selects the length: 1 selects `pkt_len_pre` and 0 selects `pkt_len_post`. Mode, length type and enable are always taken from the committed entry.
- R12: A packet accepted in cycle t gives `res_valid` = 1 with its colour in cycle t+1, and `res_valid` is 0 after a cycle without a packet. A packet to the same meter in cycle t+1 sees the state left by the packet of cycle t. A `tick` in cycle t advances the timer after the packet of cycle t has been metered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advances the 24-bit refill timer by one |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_idx | input | $clog2(DUALS) | Dual-meter index |
| pkt_len_pre | input | LEN_W | Packet length in bytes before modification |
| pkt_len_post | input | LEN_W | Packet length in bytes after modification |
| pkt_color | input | 2 | Input colour: 0 green, 1 yellow, 2/3 red |
| cfg_we | input | 1 | Configure one bucket this cycle |
| cfg_idx | input | $clog2(DUALS)+1 | Single-bucket index |
| cfg_burst | input | 24 | Maximum burst in credits |
| cfg_exp | input | 6 | Rate exponent |
| cfg_mant | input | 12 | Rate mantissa |
| cfg_mode | input | 2 | Metering behaviour 0..3 |
| cfg_pre_len | input | 1 | 1 = meter the pre-modification length |
| cfg_en | input | 1 | Meter enable |
| res_valid | output | 1 | Result valid, one cycle after the packet |
| res_color | output | 2 | Result colour: 0 green, 1 yellow, 2 red |

## Verification
The bench goes after the exact-conformance boundary, where credits equal 16·L. A design comparing with strict greater-than would turn those packets yellow or red. It runs back-to-back packets to one meter, which expose a design that reads stale credits. It refills a committed bucket past its burst while the peak is drained. Without coupling the peak would stay empty and answer red, and missing saturation would let a full bucket keep passing packets after a long idle time. Packets to a disabled meter are followed by re-enabling only the committed half. Peak credits that the disabled packets had wrongly consumed then show up as red instead of yellow. A long randomized phase with mixed modes, rates and colliding configuration writes is compared cycle by cycle against a behavioural model.

// File: rtl/dual_rate_meter.sv
module dual_rate_meter #(
  parameter int DUALS = 256,
  parameter int LEN_W = 16,
  localparam int IW = $clog2(DUALS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pkt_valid,
  input  logic [IW-1:0]    pkt_idx,
  input  logic [LEN_W-1:0] pkt_len_pre,
  input  logic [LEN_W-1:0] pkt_len_post,
  input  logic [1:0]       pkt_color,
  input  logic             cfg_we,
  input  logic [IW:0]      cfg_idx,
  input  logic [23:0]      cfg_burst,
  input  logic [5:0]       cfg_exp,
  input  logic [11:0]      cfg_mant,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_pre_len,
  input  logic             cfg_en,
  output logic             res_valid,
  output logic [1:0]       res_color
);
  localparam int NB = 2 * DUALS;
  localparam int CW = 24;
  localparam int TW = 24;
  localparam int MW = 12;
  localparam int PW = MW + TW;
  localparam int SW = PW + 2;
  localparam logic [1:0] GREEN = 2'd0, YELLOW = 2'd1, RED = 2'd2;

  logic [CW-1:0] cred_q  [NB];
  logic [TW-1:0] ts_q    [NB];
  logic [CW-1:0] burst_q [NB];
  logic [5:0]    exp_q   [NB];
  logic [MW-1:0] mant_q  [NB];
  logic [1:0]    mode_q  [NB];
  logic          pre_q   [NB];
  logic          en_q    [NB];
  logic [TW-1:0] timer;

  function automatic logic [PW-1:0] gain(input logic [MW-1:0] m, input logic [TW-1:0] n,
                                         input logic [5:0] e);
    gain = (PW'(m) * PW'(n)) >> e;
  endfunction

  logic [IW:0]     ci, pi;
  logic [PW-1:0]   add_c, add_p;
  logic [SW-1:0]   sum_c, sum_p, ovf;
  logic            full_c, full_p;
  logic [CW-1:0]   fc, fp, need, nc, np;
  logic [LEN_W-1:0] len_sel;
  logic            en, cg, pg, dc, dp;
  logic [1:0]      col;

  assign ci = {1'b0, pkt_idx};
  assign pi = ci + (IW+1)'(DUALS);
  assign en = en_q[ci];

  assign add_c  = gain(mant_q[ci], timer - ts_q[ci], exp_q[ci]);
  assign add_p  = gain(mant_q[pi], timer - ts_q[pi], exp_q[pi]);
  assign sum_c  = SW'(cred_q[ci]) + SW'(add_c);
  assign full_c = sum_c >= SW'(burst_q[ci]);
  assign fc     = full_c ? burst_q[ci] : sum_c[CW-1:0];
  assign ovf    = full_c ? sum_c - SW'(burst_q[ci]) : '0;
  assign sum_p  = SW'(cred_q[pi]) + SW'(add_p) + ovf;
  assign full_p = sum_p >= SW'(burst_q[pi]);
  assign fp     = full_p ? burst_q[pi] : sum_p[CW-1:0];

  assign len_sel = pre_q[ci] ? pkt_len_pre : pkt_len_post;
  assign need    = CW'({len_sel, 4'b0000});
  assign cg      = fc >= need;
  assign pg      = fp >= need;

  always_comb begin
    col = GREEN;
    dc  = 1'b0;
    dp  = 1'b0;
    if (en) begin
      unique case (mode_q[ci])
        2'd0: begin
          if (!pg)      col = RED;
          else if (!cg) begin col = YELLOW; dp = 1'b1; end
          else          begin col = GREEN; dc = 1'b1; dp = 1'b1; end
        end
        2'd1: begin
          if (pkt_color[1] || !pg)           col = RED;
          else if (pkt_color[0] || !cg)      begin col = YELLOW; dp = 1'b1; end
          else                               begin col = GREEN; dc = 1'b1; dp = 1'b1; end
        end
        2'd2: begin
          if (cg)       begin col = GREEN; dc = 1'b1; end
          else if (pg)  begin col = YELLOW; dp = 1'b1; end
          else          col = RED;
        end
        default: begin
          if (pkt_color[1])                  col = RED;
          else if (!pkt_color[0] && cg)      begin col = GREEN; dc = 1'b1; end
          else if (pg)                       begin col = YELLOW; dp = 1'b1; end
          else                               col = RED;
        end
      endcase
    end
  end

  assign nc = dc ? fc - need : fc;
  assign np = dp ? fp - need : fp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer     <= '0;
      res_valid <= 1'b0;
      res_color <= GREEN;
      for (int k = 0; k < NB; k++) begin
        cred_q[k]  <= '0;
        ts_q[k]    <= '0;
        burst_q[k] <= '0;
        exp_q[k]   <= '0;
        mant_q[k]  <= '0;
        mode_q[k]  <= '0;
        pre_q[k]   <= 1'b0;
        en_q[k]    <= 1'b0;
      end
    end else begin
      timer     <= timer + TW'(tick);
      res_valid <= pkt_valid;
      if (pkt_valid) res_color <= col;
      if (pkt_valid && en) begin
        cred_q[ci] <= nc;
        ts_q[ci]   <= timer;
        cred_q[pi] <= np;
        ts_q[pi]   <= timer;
      end
      if (cfg_we) begin
        cred_q[cfg_idx]  <= cfg_burst;
        ts_q[cfg_idx]    <= '0;
        burst_q[cfg_idx] <= cfg_burst;
        exp_q[cfg_idx]   <= cfg_exp;
        mant_q[cfg_idx]  <= cfg_mant;
        mode_q[cfg_idx]  <= cfg_mode;
        pre_q[cfg_idx]   <= cfg_pre_len;
        en_q[cfg_idx]    <= cfg_en;
      end
    end
  end

  // R12
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> res_valid);
  // R12
  no_stray_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !res_valid);
  // R2
  disabled_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !en) |=> (res_color == GREEN));
  // R5
  cred_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (cred_q[ci] <= burst_q[ci] && cred_q[pi] <= burst_q[pi]));
  // R8
  aware_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && en && mode_q[ci][0] && pkt_color[1]) |=> (res_color == RED));
  // R7
  color_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_color != 2'd3));
endmodule

// File: tb/dual_rate_meter_bench.sv
`timescale 1ns/1ps
module dual_rate_meter_bench;
  localparam int DUALS = 256;
  localparam int NB = 2 * DUALS;
  localparam longint MASK = 64'hFFFFFF;

  logic clk = 0, rst_n = 0;
  logic tick = 0, pkt_valid = 0, cfg_we = 0;
  logic [7:0] pkt_idx = 0;
  logic [15:0] pkt_len_pre = 0, pkt_len_post = 0;
  logic [1:0] pkt_color = 0, cfg_mode = 0;
  logic [8:0] cfg_idx = 0;
  logic [23:0] cfg_burst = 0;
  logic [5:0] cfg_exp = 0;
  logic [11:0] cfg_mant = 0;
  logic cfg_pre_len = 0, cfg_en = 0;
  logic res_valid;
  logic [1:0] res_color;

  always #2.5 clk = ~clk;

  dual_rate_meter #(.DUALS(DUALS), .LEN_W(16)) u_dual_rate_meter (
    .clk, .rst_n, .tick, .pkt_valid, .pkt_idx, .pkt_len_pre, .pkt_len_post, .pkt_color,
    .cfg_we, .cfg_idx, .cfg_burst, .cfg_exp, .cfg_mant, .cfg_mode, .cfg_pre_len, .cfg_en,
    .res_valid, .res_color);

  longint cred[NB], ts[NB], burst[NB];
  int ex[NB], mn[NB], md[NB], pre[NB], en[NB];
  longint tm = 0;
  int total = 0, bad = 0;
  bit exp_v = 0;
  int exp_c = 0;
  string exp_tag = "R1";

  // staged stimulus for the next cycle
  bit s_pv, s_tk, s_cw;
  int s_idx, s_lpre, s_lpost, s_col, s_cidx, s_burst, s_exp, s_mant, s_mode, s_pre, s_en;
  string s_tag;

  task automatic check_out();
    total++;
    if (res_valid !== exp_v) begin
      bad++;
      $display("FAIL R12 (%s): res_valid=%0d expected %0d", exp_tag, res_valid, exp_v);
    end else if (exp_v) begin
      total++;
      if (res_color !== 2'(exp_c)) begin
        bad++;
        $display("FAIL %s: res_color=%0d expected %0d", exp_tag, res_color, exp_c);
      end
    end
  endtask

  function automatic int model_pkt(int d, int lpre, int lpost, int col);
    int c = d, p = d + DUALS, r;
    longint ac, ap, sc, sp, fc, fp, ov, need;
    bit cg, pg, dc = 0, dp = 0;
    if (!en[c]) return 0;
    ac = (longint'(mn[c]) * ((tm - ts[c]) & MASK)) >> ex[c];
    ap = (longint'(mn[p]) * ((tm - ts[p]) & MASK)) >> ex[p];
    sc = cred[c] + ac;
    if (sc >= burst[c]) begin fc = burst[c]; ov = sc - burst[c]; end
    else begin fc = sc; ov = 0; end
    sp = cred[p] + ap + ov;
    fp = (sp >= burst[p]) ? burst[p] : sp;
    need = 16 * longint'(pre[c] ? lpre : lpost);
    cg = fc >= need;
    pg = fp >= need;
    case (md[c])
      0: if (!pg) r = 2; else if (!cg) begin r = 1; dp = 1; end else begin r = 0; dc = 1; dp = 1; end
      1: if (col >= 2 || !pg) r = 2; else if (col == 1 || !cg) begin r = 1; dp = 1; end
         else begin r = 0; dc = 1; dp = 1; end
      2: if (cg) begin r = 0; dc = 1; end else if (pg) begin r = 1; dp = 1; end else r = 2;
      default: if (col >= 2) r = 2; else if (col == 0 && cg) begin r = 0; dc = 1; end
               else if (pg) begin r = 1; dp = 1; end else r = 2;
    endcase
    cred[c] = dc ? fc - need : fc;
    cred[p] = dp ? fp - need : fp;
    ts[c] = tm;
    ts[p] = tm;
    return r;
  endfunction

  task automatic cyc();
    @(negedge clk);
    check_out();
    pkt_valid = s_pv; tick = s_tk; cfg_we = s_cw;
    pkt_idx = 8'(s_idx); pkt_len_pre = 16'(s_lpre); pkt_len_post = 16'(s_lpost);
    pkt_color = 2'(s_col);
    cfg_idx = 9'(s_cidx); cfg_burst = 24'(s_burst); cfg_exp = 6'(s_exp);
    cfg_mant = 12'(s_mant); cfg_mode = 2'(s_mode); cfg_pre_len = s_pre[0]; cfg_en = s_en[0];
    exp_v = s_pv;
    exp_tag = s_tag;
    if (s_pv) exp_c = model_pkt(s_idx, s_lpre, s_lpost, s_col);
    if (s_cw) begin
      cred[s_cidx] = s_burst; ts[s_cidx] = 0; burst[s_cidx] = s_burst;
      ex[s_cidx] = s_exp; mn[s_cidx] = s_mant; md[s_cidx] = s_mode;
      pre[s_cidx] = s_pre; en[s_cidx] = s_en;
    end
    if (s_tk) tm = (tm + 1) & MASK;
    s_pv = 0; s_tk = 0; s_cw = 0;
  endtask

  task automatic idle(int n, bit tk, string tag);
    for (int k = 0; k < n; k++) begin s_tk = tk; s_tag = tag; cyc(); end
  endtask

  task automatic cfg(int idx, int b, int e, int m, int mode, int pl, int on);
    s_cw = 1; s_cidx = idx; s_burst = b; s_exp = e; s_mant = m; s_mode = mode;
    s_pre = pl; s_en = on; s_tag = "R3";
    cyc();
  endtask

  task automatic pkt(int idx, int lpre, int lpost, int col, string tag);
    s_pv = 1; s_idx = idx; s_lpre = lpre; s_lpost = lpost; s_col = col; s_tag = tag;
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NB; k++) begin
      cred[k] = 0; ts[k] = 0; burst[k] = 0; ex[k] = 0; mn[k] = 0; md[k] = 0; pre[k] = 0; en[k] = 0;
    end
    s_pv = 0; s_tk = 0; s_cw = 0; s_tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(3, 0, "R1");
    pkt(5, 100, 100, 2, "R1");
    pkt(200, 1, 1, 1, "R1");
    // mode 0 with no refill, then exact boundary
    cfg(1, 1600, 0, 0, 0, 0, 1);
    cfg(257, 3200, 0, 0, 0, 0, 1);
    for (int k = 0; k < 4; k++) pkt(1, 0, 60, 0, "R7");
    cfg(11, 960, 0, 0, 0, 0, 1);
    cfg(267, 960, 0, 0, 0, 0, 1);
    pkt(11, 0, 60, 0, "R4");
    pkt(11, 0, 1, 0, "R4");
    // mode 1 colour-aware
    cfg(2, 800, 0, 0, 1, 0, 1);
    cfg(258, 1600, 0, 0, 1, 0, 1);
    pkt(2, 0, 10, 2, "R8"); pkt(2, 0, 10, 1, "R8"); pkt(2, 0, 40, 0, "R8");
    pkt(2, 0, 20, 0, "R8"); pkt(2, 0, 30, 1, "R8"); pkt(2, 0, 30, 0, "R8");
    // mode 2
    cfg(3, 800, 0, 0, 2, 0, 1);
    cfg(259, 800, 0, 0, 2, 0, 1);
    for (int k = 0; k < 5; k++) pkt(3, 0, 30, 0, "R9");
    // mode 3
    cfg(4, 800, 0, 0, 3, 0, 1);
    cfg(260, 800, 0, 0, 3, 0, 1);
    pkt(4, 0, 10, 3, "R10"); pkt(4, 0, 30, 1, "R10"); pkt(4, 0, 30, 0, "R10");
    pkt(4, 0, 30, 0, "R10"); pkt(4, 0, 30, 1, "R10");
    // refill with saturation and fractional rate
    cfg(6, 1600, 0, 16, 0, 0, 1);
    cfg(262, 1600, 1, 3, 0, 0, 1);
    pkt(6, 0, 100, 0, "R5"); pkt(6, 0, 1, 0, "R5");
    idle(7, 1, "R5");
    pkt(6, 0, 5, 0, "R5"); pkt(6, 0, 6, 0, "R5");
    idle(300, 1, "R5");
    pkt(6, 0, 100, 0, "R5"); pkt(6, 0, 1, 0, "R5");
    // coupling: committed overflow feeds the drained peak
    cfg(7, 160, 0, 160, 0, 0, 1);
    cfg(263, 3200, 0, 0, 0, 0, 1);
    pkt(7, 0, 200, 0, "R6"); pkt(7, 0, 1, 0, "R6");
    idle(30, 1, "R6");
    pkt(7, 0, 150, 0, "R6"); pkt(7, 0, 150, 0, "R6");
    // length type
    cfg(8, 800, 0, 0, 0, 1, 1); cfg(264, 800, 0, 0, 0, 0, 1);
    cfg(9, 800, 0, 0, 0, 0, 1); cfg(265, 800, 0, 0, 0, 1, 1);
    pkt(8, 50, 10, 0, "R11"); pkt(8, 1, 40, 0, "R11");
    pkt(9, 10, 50, 0, "R11"); pkt(9, 40, 1, 0, "R11");
    // disabled meter leaves the peak bucket alone
    cfg(10, 0, 0, 0, 0, 0, 0);
    cfg(266, 160, 0, 0, 0, 0, 1);
    for (int k = 0; k < 4; k++) pkt(10, 10, 10, 0, "R2");
    cfg(10, 0, 0, 0, 0, 0, 1);
    pkt(10, 10, 10, 0, "R2");
    pkt(10, 10, 10, 0, "R2");
    // packet and configuration of the same bucket in one cycle
    s_cw = 1; s_cidx = 1; s_burst = 320; s_exp = 0; s_mant = 0; s_mode = 0; s_pre = 0; s_en = 1;
    pkt(1, 0, 10, 0, "R3");
    pkt(1, 0, 10, 0, "R3");
    pkt(1, 0, 10, 0, "R3");
    // randomized mix
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 9) == 0) begin
        s_cw = 1; s_cidx = $urandom_range(0, 15) + ($urandom_range(0, 1) ? DUALS : 0);
        s_burst = $urandom_range(0, 20000); s_exp = $urandom_range(0, 14);
        s_mant = $urandom_range(0, 4095); s_mode = $urandom_range(0, 3);
        s_pre = $urandom_range(0, 1); s_en = ($urandom_range(0, 7) != 0);
      end
      s_tk = $urandom_range(0, 1);
      if ($urandom_range(0, 3) != 0) begin
        s_pv = 1; s_idx = $urandom_range(0, 15);
        s_lpre = $urandom_range(0, 300); s_lpost = $urandom_range(0, 300);
        s_col = $urandom_range(0, 3);
        s_tag = "R12 random";
      end else s_tag = "R12 random";
      cyc();
    end
    idle(2, 0, "R12");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule